// File: doc/BRIEF.md
# Message Match-List Search Engine

This block sits on the receive side of a network interface and decides where an incoming put request lands. Each request carries a process number, an index into that process's table, a set of match bits, a payload length and an acknowledgment request. The engine reads the selected table slot to find the head of a linked list of match entries. It then walks the list one entry per clock until an entry's match bits agree with the request. Bits the entry marks as ignored do not take part in the comparison.

On a hit whose buffer is large enough, the result carries the destination buffer base and the payload length for the DMA stage. The result also says whether the entry wants an event record and whether the initiator wants an acknowledgment. A request that finds no entry is flagged unexpected and goes to the unexpected-message path. A request that matches an entry whose buffer is too small gets a length error and no handoff.

The table and the list entries are written through a plain configuration port. List pointer value 0 means null, so entry 0 is never walked. The match bits follow a fixed field layout: protocol in bits 15:14, communicator in bits 13:10, sender rank in bits 9:4 and message tag in bits 3:0. The comparison is bitwise, so the engine does not interpret these fields.

Requests enter on a valid/ready stream, and results leave on another. The engine takes a request only while it is idle with no result pending. A result stays on the outputs until the consumer raises `res_ready`, and no new request is taken while a result waits, so back-pressure on the result stream reaches the request stream.

Top module: `mlse_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `res_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until its result has been consumed. A request held on the inputs meanwhile is taken afterwards and is not lost.
- R3: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and every result field holds its value.
- R4: The list head is the table slot at address {process, index}. A head of 0 gives an unexpected result on the edge that takes the request (0 walk cycles).
- R5: The walk starts at the head and follows next pointers. It stops at the first entry with ((request bits XOR entry bits) AND NOT ignore mask) equal to 0, and `res_entry` is that entry's pointer.
- R6: A match-bit position whose ignore-mask bit is 1 does not affect the comparison.
- R7: On a match with request length ≤ entry size, `res_hit`=1, `res_base` is the entry base and `res_len` is the request length.
- R8: On a match with request length > entry size, `res_len_err`=1, while `res_hit`, `res_evt` and `res_ack` are 0.
- R9: `res_evt` is 1 exactly when the result is a hit and the matched entry's event flag is 1.
- R10: `res_ack` is 1 exactly when the result is a hit and the request asked for an acknowledgment.
- R11: When the walk reaches an entry with next pointer 0 and no entry has matched, the result is `res_unexp`=1 with `res_hit`=0. Exactly one of `res_hit`, `res_unexp` and `res_len_err` is 1 in every result.
- R12: When MAX_WALK entries have been examined without a match and the last of them has a non-null next pointer, the result is `res_unexp`=1 together with `res_walk_err`=1.
- R13: A match or end of list at walk position k (head = position 1) raises `res_valid` k clock edges after the edge that took the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write one table slot |
| tbl_wr_addr | input | PROC_W+IDX_W | Slot address {process, index} |
| tbl_wr_head | input | PTR_W | List head pointer (0 = empty list) |
| ent_wr_en | input | 1 | Write one list entry |
| ent_wr_addr | input | PTR_W | Entry pointer |
| ent_wr_bits | input | MB_W | Entry match bits |
| ent_wr_ignore | input | MB_W | Ignore mask (1 = don't care) |
| ent_wr_base | input | ADDR_W | Buffer base address |
| ent_wr_size | input | LEN_W | Buffer size |
| ent_wr_evt | input | 1 | Event-record request flag |
| ent_wr_next | input | PTR_W | Next pointer (0 = end) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_proc | input | PROC_W | Process number |
| req_idx | input | IDX_W | Table index |
| req_bits | input | MB_W | Request match bits |
| req_len | input | LEN_W | Payload length |
| req_want_ack | input | 1 | Initiator asks for acknowledgment |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Match, hand buffer to DMA |
| res_unexp | output | 1 | No match, unexpected message |
| res_len_err | output | 1 | Match but buffer too small |
| res_walk_err | output | 1 | Walk stopped at MAX_WALK |
| res_evt | output | 1 | Write event record |
| res_ack | output | 1 | Send acknowledgment |
| res_entry | output | PTR_W | Matched entry pointer |
| res_base | output | ADDR_W | Destination buffer base |
| res_len | output | LEN_W | Payload length |

## Verification
The hardest case to reach from the ports is the walk cap. It needs a list longer than MAX_WALK, built one entry at a time through the configuration port. Two requests then run against that list. One matches exactly at position MAX_WALK, which must still hit. The other matches only one position later, which must stop with a walk error after MAX_WALK cycles. Back-pressure is reached by holding `res_ready` low with a second request waiting at the input. This shows that the result holds and that the waiting request is taken only after the result is consumed.

// File: rtl/mlse_pkg.sv
package mlse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } mlse_state_e;

  // match-bit field layout (bitwise compare; layout is informative)
  localparam int MB_TAG_LSB   = 0;
  localparam int MB_RANK_LSB  = 4;
  localparam int MB_COMM_LSB  = 10;
  localparam int MB_PROTO_LSB = 14;
endpackage

// File: rtl/mlse_table.sv
module mlse_table #(
  parameter int SLOT_W = 4,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_addr,
  input  logic [PTR_W-1:0]  wr_head,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic [PTR_W-1:0]  rd_head
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [PTR_W-1:0] heads [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) heads[i] <= '0;
    end else if (wr_en) begin
      heads[wr_addr] <= wr_head;
    end
  end

  assign rd_head = heads[rd_addr];
endmodule

// File: rtl/mlse_list_mem.sv
module mlse_list_mem #(
  parameter int PTR_W  = 4,
  parameter int MB_W   = 16,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [MB_W-1:0]   wr_bits,
  input  logic [MB_W-1:0]   wr_ignore,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [LEN_W-1:0]  wr_size,
  input  logic              wr_evt,
  input  logic [PTR_W-1:0]  wr_next,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [MB_W-1:0]   rd_bits,
  output logic [MB_W-1:0]   rd_ignore,
  output logic [ADDR_W-1:0] rd_base,
  output logic [LEN_W-1:0]  rd_size,
  output logic              rd_evt,
  output logic [PTR_W-1:0]  rd_next
);
  localparam int DEPTH = 1 << PTR_W;
  localparam int ROW_W = 2*MB_W + ADDR_W + LEN_W + 1 + PTR_W;

  logic [ROW_W-1:0] rows [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) rows[wr_addr] <= {wr_bits, wr_ignore, wr_base, wr_size, wr_evt, wr_next};
  end

  assign {rd_bits, rd_ignore, rd_base, rd_size, rd_evt, rd_next} = rows[rd_addr];
endmodule

// File: rtl/mlse_match_cmp.sv
module mlse_match_cmp #(
  parameter int MB_W = 16
) (
  input  logic [MB_W-1:0] want,
  input  logic [MB_W-1:0] have,
  input  logic [MB_W-1:0] ignore,
  output logic            agree
);
  logic [MB_W-1:0] bit_ok;

  for (genvar b = 0; b < MB_W; b++) begin : g_bit
    assign bit_ok[b] = ignore[b] | ~(want[b] ^ have[b]);
  end

  assign agree = &bit_ok;
endmodule

// File: rtl/mlse_engine.sv
module mlse_engine
  import mlse_pkg::*;
#(
  parameter int PROC_W   = 2,
  parameter int IDX_W    = 2,
  parameter int PTR_W    = 4,
  parameter int MB_W     = 16,
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 12,
  parameter int MAX_WALK = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tbl_wr_en,
  input  logic [PROC_W+IDX_W-1:0] tbl_wr_addr,
  input  logic [PTR_W-1:0]        tbl_wr_head,
  input  logic                    ent_wr_en,
  input  logic [PTR_W-1:0]        ent_wr_addr,
  input  logic [MB_W-1:0]         ent_wr_bits,
  input  logic [MB_W-1:0]         ent_wr_ignore,
  input  logic [ADDR_W-1:0]       ent_wr_base,
  input  logic [LEN_W-1:0]        ent_wr_size,
  input  logic                    ent_wr_evt,
  input  logic [PTR_W-1:0]        ent_wr_next,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [PROC_W-1:0]       req_proc,
  input  logic [IDX_W-1:0]        req_idx,
  input  logic [MB_W-1:0]         req_bits,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    req_want_ack,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic                    res_hit,
  output logic                    res_unexp,
  output logic                    res_len_err,
  output logic                    res_walk_err,
  output logic                    res_evt,
  output logic                    res_ack,
  output logic [PTR_W-1:0]        res_entry,
  output logic [ADDR_W-1:0]       res_base,
  output logic [LEN_W-1:0]        res_len
);
  localparam int SLOT_W = PROC_W + IDX_W;
  localparam int STEP_W = $clog2(MAX_WALK + 1);
  localparam logic [STEP_W-1:0] STEP_LIM = STEP_W'(MAX_WALK);

  mlse_state_e       state;
  logic [MB_W-1:0]   r_bits;
  logic [LEN_W-1:0]  r_len;
  logic              r_ack;
  logic [PTR_W-1:0]  cur_ptr;
  logic [STEP_W-1:0] steps;

  logic [PTR_W-1:0]  head;
  logic [MB_W-1:0]   e_bits, e_ignore;
  logic [ADDR_W-1:0] e_base;
  logic [LEN_W-1:0]  e_size;
  logic              e_evt;
  logic [PTR_W-1:0]  e_next;
  logic              agree;

  mlse_table #(.SLOT_W(SLOT_W), .PTR_W(PTR_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_en),
    .wr_addr (tbl_wr_addr),
    .wr_head (tbl_wr_head),
    .rd_addr ({req_proc, req_idx}),
    .rd_head (head)
  );

  mlse_list_mem #(.PTR_W(PTR_W), .MB_W(MB_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_list (
    .clk       (clk),
    .wr_en     (ent_wr_en),
    .wr_addr   (ent_wr_addr),
    .wr_bits   (ent_wr_bits),
    .wr_ignore (ent_wr_ignore),
    .wr_base   (ent_wr_base),
    .wr_size   (ent_wr_size),
    .wr_evt    (ent_wr_evt),
    .wr_next   (ent_wr_next),
    .rd_addr   (cur_ptr),
    .rd_bits   (e_bits),
    .rd_ignore (e_ignore),
    .rd_base   (e_base),
    .rd_size   (e_size),
    .rd_evt    (e_evt),
    .rd_next   (e_next)
  );

  mlse_match_cmp #(.MB_W(MB_W)) u_cmp (
    .want   (r_bits),
    .have   (e_bits),
    .ignore (e_ignore),
    .agree  (agree)
  );

  assign req_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      r_bits       <= '0;
      r_len        <= '0;
      r_ack        <= 1'b0;
      cur_ptr      <= '0;
      steps        <= '0;
      res_hit      <= 1'b0;
      res_unexp    <= 1'b0;
      res_len_err  <= 1'b0;
      res_walk_err <= 1'b0;
      res_evt      <= 1'b0;
      res_ack      <= 1'b0;
      res_entry    <= '0;
      res_base     <= '0;
      res_len      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            r_bits       <= req_bits;
            r_len        <= req_len;
            r_ack        <= req_want_ack;
            res_len      <= req_len;
            res_hit      <= 1'b0;
            res_len_err  <= 1'b0;
            res_walk_err <= 1'b0;
            res_evt      <= 1'b0;
            res_ack      <= 1'b0;
            res_entry    <= '0;
            res_base     <= '0;
            if (head == '0) begin
              res_unexp <= 1'b1;
              state     <= ST_RESP;
            end else begin
              res_unexp <= 1'b0;
              cur_ptr   <= head;
              steps     <= STEP_W'(1);
              state     <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (agree) begin
            res_entry <= cur_ptr;
            res_base  <= e_base;
            if (r_len > e_size) begin
              res_len_err <= 1'b1;
            end else begin
              res_hit <= 1'b1;
              res_evt <= e_evt;
              res_ack <= r_ack;
            end
            state <= ST_RESP;
          end else if (e_next == '0) begin
            res_unexp <= 1'b1;
            state     <= ST_RESP;
          end else if (steps == STEP_LIM) begin
            res_unexp    <= 1'b1;
            res_walk_err <= 1'b1;
            state        <= ST_RESP;
          end else begin
            cur_ptr <= e_next;
            steps   <= steps + STEP_W'(1);
          end
        end
        ST_RESP: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mlse_chk.sv
module mlse_chk #(
  parameter int PTR_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 12,
  parameter int MAX_WALK = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic              res_unexp,
  input logic              res_len_err,
  input logic              res_walk_err,
  input logic              res_evt,
  input logic              res_ack,
  input logic [PTR_W-1:0]  res_entry,
  input logic [ADDR_W-1:0] res_base,
  input logic [LEN_W-1:0]  res_len
);
  localparam int CW = $clog2(MAX_WALK + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] walk_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) walk_cnt <= '0;
    else if (req_valid && req_ready) walk_cnt <= '0;
    else if (!req_ready && !res_valid && walk_cnt != CMAX) walk_cnt <= walk_cnt + CW'(1);
  end

  // R2
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_base) && $stable(res_entry)
      && $stable(res_len) && $stable(res_hit) && $stable(res_unexp)));

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_hit, res_unexp, res_len_err}) == 1));

  // R9
  evt_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_evt) |-> res_hit);

  // R10
  ack_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ack) |-> res_hit);

  // R12
  walk_err_unexp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_walk_err) |-> res_unexp);

  // R12
  walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (walk_cnt <= CW'(MAX_WALK)));
endmodule

bind mlse_engine mlse_chk #(
  .PTR_W(PTR_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_WALK(MAX_WALK)
) u_mlse_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_hit      (res_hit),
  .res_unexp    (res_unexp),
  .res_len_err  (res_len_err),
  .res_walk_err (res_walk_err),
  .res_evt      (res_evt),
  .res_ack      (res_ack),
  .res_entry    (res_entry),
  .res_base     (res_base),
  .res_len      (res_len)
);

// File: tb/test_mlse_engine.sv
module test_mlse_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        tbl_wr_en = 0;
  logic [3:0]  tbl_wr_addr = 0;
  logic [3:0]  tbl_wr_head = 0;
  logic        ent_wr_en = 0;
  logic [3:0]  ent_wr_addr = 0;
  logic [15:0] ent_wr_bits = 0, ent_wr_ignore = 0, ent_wr_base = 0;
  logic [11:0] ent_wr_size = 0;
  logic        ent_wr_evt = 0;
  logic [3:0]  ent_wr_next = 0;
  logic        req_valid = 0, req_ready;
  logic [1:0]  req_proc = 0, req_idx = 0;
  logic [15:0] req_bits = 0;
  logic [11:0] req_len = 0;
  logic        req_want_ack = 0;
  logic        res_valid, res_ready = 1;
  logic        res_hit, res_unexp, res_len_err, res_walk_err, res_evt, res_ack;
  logic [3:0]  res_entry;
  logic [15:0] res_base;
  logic [11:0] res_len;

  mlse_engine i_mlse_engine (.*);

  int tests = 0;
  int fails = 0;

  function automatic logic [15:0] mb(input int p, input int c, input int r, input int t);
    return {p[1:0], c[3:0], r[5:0], t[3:0]};
  endfunction

  // kind: 0 hit, 1 unexpected, 2 length error, 3 walk error
  typedef struct packed {
    logic [1:0]  proc;
    logic [1:0]  idx;
    logic [15:0] bits;
    logic [11:0] len;
    logic        ack;
    logic [1:0]  kind;
    logic [3:0]  entry;
    logic [15:0] base;
    logic        evt;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, mb(0,1,5,3),  12'd80,  1'b1, 2'd0, 4'd1,  16'h1000, 1'b1, 4'd1}, // R5 R7 R9 R10
    '{2'd0, 2'd0, mb(0,1,5,9),  12'd50,  1'b0, 2'd0, 4'd2,  16'h2000, 1'b0, 4'd2}, // R6
    '{2'd0, 2'd0, mb(0,1,5,3),  12'd101, 1'b1, 2'd2, 4'd1,  16'h1000, 1'b0, 4'd1}, // R8
    '{2'd0, 2'd0, mb(1,2,3,4),  12'd200, 1'b1, 2'd0, 4'd3,  16'h3000, 1'b1, 4'd3}, // R7 size edge
    '{2'd0, 2'd0, mb(2,0,0,0),  12'd8,   1'b1, 2'd1, 4'd0,  16'h0000, 1'b0, 4'd3}, // R11
    '{2'd0, 2'd1, mb(0,1,5,3),  12'd8,   1'b0, 2'd1, 4'd0,  16'h0000, 1'b0, 4'd0}, // R4
    '{2'd1, 2'd0, mb(0,1,5,3),  12'd8,   1'b0, 2'd1, 4'd0,  16'h0000, 1'b0, 4'd0}, // R4
    '{2'd1, 2'd2, 16'h010B,     12'd64,  1'b1, 2'd0, 4'd11, 16'h40B0, 1'b0, 4'd8}, // R12 R13
    '{2'd1, 2'd2, 16'h010C,     12'd64,  1'b1, 2'd3, 4'd0,  16'h0000, 1'b0, 4'd8}, // R12
    '{2'd1, 2'd2, 16'h0104,     12'd1,   1'b0, 2'd0, 4'd4,  16'h4040, 1'b0, 4'd1}, // R13
    '{2'd0, 2'd0, mb(0,1,5,15), 12'd0,   1'b1, 2'd0, 4'd2,  16'h2000, 1'b0, 4'd2}  // R6 R10
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_tbl(input int slot, input int head);
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_addr = slot[3:0]; tbl_wr_head = head[3:0];
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic wr_ent(input int ptr, input logic [15:0] bits, input logic [15:0] ign,
                        input logic [15:0] base, input int size, input logic evt, input int nxt);
    @(negedge clk);
    ent_wr_en = 1; ent_wr_addr = ptr[3:0]; ent_wr_bits = bits; ent_wr_ignore = ign;
    ent_wr_base = base; ent_wr_size = size[11:0]; ent_wr_evt = evt; ent_wr_next = nxt[3:0];
    @(negedge clk);
    ent_wr_en = 0;
  endtask

  task automatic run_vec(input int n);
    vec_t v = VECS[n];
    int lat = 0;
    string tag;
    tag = $sformatf("vec%0d", n);
    @(negedge clk);
    check("R2", {tag, " ready before"}, {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_proc = v.proc; req_idx = v.idx; req_bits = v.bits;
    req_len = v.len; req_want_ack = v.ack; res_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!res_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R13", {tag, " latency"}, lat, {28'd0, v.lat});
    check("R11", {tag, " unexp"}, {31'd0, res_unexp}, {31'd0, (v.kind == 2'd1 || v.kind == 2'd3)});
    check("R12", {tag, " walk_err"}, {31'd0, res_walk_err}, {31'd0, v.kind == 2'd3});
    check("R7", {tag, " hit"}, {31'd0, res_hit}, {31'd0, v.kind == 2'd0});
    check("R8", {tag, " len_err"}, {31'd0, res_len_err}, {31'd0, v.kind == 2'd2});
    check("R9", {tag, " evt"}, {31'd0, res_evt}, {31'd0, v.kind == 2'd0 && v.evt});
    check("R10", {tag, " ack"}, {31'd0, res_ack}, {31'd0, v.kind == 2'd0 && v.ack});
    if (v.kind == 2'd0 || v.kind == 2'd2) begin
      check("R5", {tag, " entry"}, {28'd0, res_entry}, {28'd0, v.entry});
      check("R7", {tag, " base"}, {16'd0, res_base}, {16'd0, v.base});
    end
    if (v.kind == 2'd0) check("R7", {tag, " len"}, {20'd0, res_len}, {20'd0, v.len});
    @(negedge clk);
    check("R2", {tag, " consumed"}, {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hold_lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);
    check("R1", "res_valid after reset", {31'd0, res_valid}, 32'd0);

    // list for slot (0,0): 1 -> 2 -> 3
    wr_ent(1, mb(0,1,5,3), 16'h0000, 16'h1000, 100, 1'b1, 2);
    wr_ent(2, mb(0,1,5,7), 16'h000F, 16'h2000, 50,  1'b0, 3);
    wr_ent(3, mb(1,2,3,4), 16'h0000, 16'h3000, 200, 1'b1, 0);
    wr_tbl(0, 1);
    // long list for slot (1,2): 4 -> 5 -> ... -> 13
    for (int i = 4; i <= 13; i++)
      wr_ent(i, 16'h0100 + 16'(i), 16'h0000, 16'h4000 + 16'(i * 16), 64, 1'b0, (i == 13) ? 0 : i + 1);
    wr_tbl(6, 4);

    for (int n = 0; n < NV; n++) run_vec(n);

    // back-pressure: hold result, second request waits on the input (R2, R3)
    @(negedge clk);
    res_ready = 0;
    req_valid = 1; req_proc = 0; req_idx = 0; req_bits = mb(0,1,5,3); req_len = 4; req_want_ack = 0;
    @(posedge clk);
    @(negedge clk);
    req_proc = 0; req_idx = 1; req_bits = 16'hFFFF;
    hold_lat = 0;
    while (!res_valid && hold_lat < 20) begin @(negedge clk); hold_lat++; end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3", "held valid", {31'd0, res_valid}, 32'd1);
      check("R3", "held base", {16'd0, res_base}, 32'h1000);
      check("R3", "held hit", {31'd0, res_hit}, 32'd1);
      check("R2", "not ready while held", {31'd0, req_ready}, 32'd0);
    end
    res_ready = 1;
    @(negedge clk);
    check("R2", "ready after consume", {31'd0, req_ready}, 32'd1);
    check("R2", "result gone", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    req_valid = 0;
    check("R2", "waiting request taken", {31'd0, res_valid}, 32'd1);
    check("R4", "waiting request empty slot", {31'd0, res_unexp}, 32'd1);
    @(negedge clk);

    // R6: mask change on entry 1 lets any tag match
    wr_ent(1, mb(0,1,5,3), 16'h000F, 16'h1000, 100, 1'b0, 2);
    @(negedge clk);
    req_valid = 1; req_proc = 0; req_idx = 0; req_bits = mb(0,1,5,12); req_len = 1; req_want_ack = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R6", "masked tag hit", {31'd0, res_hit}, 32'd0);
    @(negedge clk);
    check("R6", "masked tag hit", {31'd0, res_hit}, 32'd1);
    check("R5", "masked tag entry", {28'd0, res_entry}, 32'd1);
    check("R9", "evt flag cleared", {31'd0, res_evt}, 32'd0);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule